// File: doc/BRIEF.md
# Three-Wire Tuning Word Receiver

This block takes a tuning control word from a host over a three-wire serial bus (serial data, serial clock and an enable strobe). It turns that word into a frequency divisor and four general-purpose port bits. The bus pins are asynchronous to the block. All three bus lines and the mode input pass through a synchroniser and are edge-detected in a fast system clock domain.

Bits are taken on rising edges of the serial clock, but only while enable is high. Bus clock activity while enable is low leaves the receiver untouched. The received bits build up in a shift register, and the visible outputs do not change during transfer. The outputs change only when enable falls, and only if the number of bits received fits the current mode. A host can therefore stream a new word while the old divisor stays in force, and the new value takes effect in a single step.

Field layout (shared by all requirements): the first four bits on the wire are the port bits, followed by the divisor, most significant bit first. With `mode_i` high the divisor is 14 bits and the word is 18 bits. With `mode_i` low the divisor is 15 bits and the word is 19 bits.

Top module: `tw_receiver`

## Requirements
- R1: After reset, `div_o` and `port_o` are zero and `word_valid_o` is low.
- R2: With `mode_i` high, an 18-bit word is accepted. `div_o[13:0]` holds the last 14 bits received (MSB first) and `div_o[14]` is 0.
- R3: With `mode_i` low, a 19-bit word is accepted and `div_o[14:0]` holds the last 15 bits received (MSB first).
- R4: A bit is sampled only on a rising edge of `bus_clk_i` while `bus_en_i` is high. Rising edges while enable is low are not counted, so a correct word that follows them is still accepted and the outputs do not move.
- R5: `div_o` and `port_o` change only in the cycle after a falling edge of `bus_en_i` is detected. They stay unchanged while a word is being shifted in.
- R6: If the bit count at the enable fall differs from the mode's word length (too few, too many or none), the word is discarded and `div_o`/`port_o` keep their previous values.
- R7: `word_valid_o` is high for exactly one system clock cycle each time the outputs load, and is low at all other times.
- R8: `port_o[3]` takes the first bit on the wire, `port_o[2]` the second, `port_o[1]` the third and `port_o[0]` the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk_i | input | 1 | Serial bus clock (asynchronous) |
| bus_data_i | input | 1 | Serial bus data (asynchronous) |
| bus_en_i | input | 1 | Serial bus enable; high frames a word |
| mode_i | input | 1 | High: 14-bit divisor; low: 15-bit divisor |
| div_o | output | DIV_W_LONG (15) | Buffered divisor |
| port_o | output | PORT_W (4) | Buffered general-purpose port bits |
| word_valid_o | output | 1 | One-cycle strobe when the buffers load |

## Verification
A wrong bit counter is the hidden state that matters most. If it drifts, for example by counting bus clocks while enable is low, the next correct word is refused. The fault then shows at the ports as a missing `word_valid_o` strobe and a stale divisor, a few system cycles after that word's enable fall. A shift register or field mapping error shows up in the same strobe cycle as a wrong divisor or port value. A holding register that loads out of turn shows up as outputs moving during a transfer, which the bench checks halfway through each word.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int unsigned TW_DIV_W_LONG = 15;
  localparam int unsigned TW_PORT_W     = 4;
  localparam int unsigned TW_SYNC_STG   = 2;
endpackage

// File: rtl/tw_sync.sv
// Multi-bit flop chain for asynchronous single-bit control lines (STAGES >= 2).
module tw_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/tw_shift.sv
// Serial assembly register with a saturating bit counter.
module tw_shift #(
  parameter int unsigned WORD_W = 19,
  localparam int unsigned CNT_W = $clog2(WORD_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb_i,
  input  logic              bit_val_i,
  input  logic              clear_i,
  output logic [WORD_W-1:0] sr_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(WORD_W + 1);

  logic [WORD_W-1:0] sr_q, sr_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;

  always_comb begin
    sr_n  = sr_q;
    cnt_n = cnt_q;
    if (clear_i) begin
      cnt_n = '0;
    end else if (bit_stb_i) begin
      sr_n = {sr_q[WORD_W-2:0], bit_val_i};
      if (cnt_q != CNT_SAT) cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_n;
      cnt_q <= cnt_n;
    end
  end

  assign sr_o  = sr_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/tw_hold.sv
// Holding buffers: load on enable fall when the count fits the mode.
module tw_hold #(
  parameter int unsigned DIV_W_LONG = 15,
  parameter int unsigned PORT_W     = 4,
  localparam int unsigned DIV_W_SHORT = DIV_W_LONG - 1,
  localparam int unsigned WORD_LONG   = DIV_W_LONG + PORT_W,
  localparam int unsigned WORD_SHORT  = DIV_W_SHORT + PORT_W,
  localparam int unsigned CNT_W       = $clog2(WORD_LONG + 2)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_req_i,
  input  logic                  mode_short_i,
  input  logic [WORD_LONG-1:0]  sr_i,
  input  logic [CNT_W-1:0]      cnt_i,
  output logic [DIV_W_LONG-1:0] div_o,
  output logic [PORT_W-1:0]     port_o,
  output logic                  valid_o
);
  logic [DIV_W_LONG-1:0] div_q, div_n;
  logic [PORT_W-1:0]     port_q, port_n;
  logic                  valid_q, valid_n;
  logic                  len_ok;

  assign len_ok = mode_short_i ? (cnt_i == CNT_W'(WORD_SHORT))
                               : (cnt_i == CNT_W'(WORD_LONG));

  always_comb begin
    div_n   = div_q;
    port_n  = port_q;
    valid_n = 1'b0;
    if (load_req_i && len_ok) begin
      valid_n = 1'b1;
      if (mode_short_i) begin
        div_n  = {1'b0, sr_i[DIV_W_SHORT-1:0]};
        port_n = sr_i[WORD_SHORT-1:DIV_W_SHORT];
      end else begin
        div_n  = sr_i[DIV_W_LONG-1:0];
        port_n = sr_i[WORD_LONG-1:DIV_W_LONG];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      port_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      div_q   <= div_n;
      port_q  <= port_n;
      valid_q <= valid_n;
    end
  end

  assign div_o   = div_q;
  assign port_o  = port_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/tw_receiver.sv
module tw_receiver #(
  parameter int unsigned DIV_W_LONG = tw_pkg::TW_DIV_W_LONG,
  parameter int unsigned PORT_W     = tw_pkg::TW_PORT_W,
  parameter int unsigned SYNC_STG   = tw_pkg::TW_SYNC_STG
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_clk_i,
  input  logic                  bus_data_i,
  input  logic                  bus_en_i,
  input  logic                  mode_i,
  output logic [DIV_W_LONG-1:0] div_o,
  output logic [PORT_W-1:0]     port_o,
  output logic                  word_valid_o
);
  localparam int unsigned WORD_LONG = DIV_W_LONG + PORT_W;
  localparam int unsigned CNT_W     = $clog2(WORD_LONG + 2);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [3:0] pins_s;
  logic       clk_s, data_s, en_s, mode_s;

  tw_sync #(.W(4), .STAGES(SYNC_STG)) sync_i (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   ({mode_i, bus_en_i, bus_data_i, bus_clk_i}),
    .q_o   (pins_s)
  );
  assign {mode_s, en_s, data_s, clk_s} = pins_s;

  // Edge detection on the synchronised bus lines.
  logic clk_d_q, en_d_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      clk_d_q <= 1'b0;
      en_d_q  <= 1'b0;
    end else begin
      clk_d_q <= clk_s;
      en_d_q  <= en_s;
    end
  end

  logic bit_stb, en_fall;
  assign bit_stb = en_s & clk_s & ~clk_d_q;
  assign en_fall = ~en_s & en_d_q;

  logic [WORD_LONG-1:0] sr;
  logic [CNT_W-1:0]     bit_cnt;

  tw_shift #(.WORD_W(WORD_LONG)) shift_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bit_stb_i (bit_stb),
    .bit_val_i (data_s),
    .clear_i   (en_fall),
    .sr_o      (sr),
    .cnt_o     (bit_cnt)
  );

  tw_hold #(.DIV_W_LONG(DIV_W_LONG), .PORT_W(PORT_W)) hold_i (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .load_req_i   (en_fall),
    .mode_short_i (mode_s),
    .sr_i         (sr),
    .cnt_i        (bit_cnt),
    .div_o        (div_o),
    .port_o       (port_o),
    .valid_o      (word_valid_o)
  );
endmodule

// File: rtl/tw_receiver_chk.sv
module tw_receiver_chk #(
  parameter int unsigned DIV_W_LONG = 15,
  parameter int unsigned PORT_W     = 4,
  parameter int unsigned CNT_W      = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  en_fall,
  input logic                  mode_s,
  input logic [CNT_W-1:0]      bit_cnt,
  input logic [DIV_W_LONG-1:0] div_o,
  input logic [PORT_W-1:0]     port_o,
  input logic                  word_valid_o
);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(DIV_W_LONG + PORT_W + 1);

  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |=> !word_valid_o);

  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid_o |-> ($stable(div_o) && $stable(port_o)));

  assert_load_after_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> $past(en_fall));

  assert_short_msb_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid_o && mode_s) |-> (div_o[DIV_W_LONG-1] == 1'b0));

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_LIM);
endmodule

bind tw_receiver tw_receiver_chk #(
  .DIV_W_LONG (DIV_W_LONG),
  .PORT_W     (PORT_W),
  .CNT_W      (CNT_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .en_fall      (en_fall),
  .mode_s       (mode_s),
  .bit_cnt      (bit_cnt),
  .div_o        (div_o),
  .port_o       (port_o),
  .word_valid_o (word_valid_o)
);

// File: tb/tw_receiver_tb.sv
module tw_receiver_tb_top;
  localparam int DW = 15;
  localparam int PW = 4;
  localparam int T  = 4; // system clocks per bus half-phase

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_clk = 1'b0, bus_data = 1'b0, bus_en = 1'b0, mode = 1'b1;
  logic [DW-1:0] div_o;
  logic [PW-1:0] port_o;
  logic          word_valid_o;

  always #2.5 clk = ~clk; // 200 MHz

  tw_receiver dut_i (
    .clk(clk), .rst_n(rst_n), .bus_clk_i(bus_clk), .bus_data_i(bus_data),
    .bus_en_i(bus_en), .mode_i(mode), .div_o(div_o), .port_o(port_o),
    .word_valid_o(word_valid_o)
  );

  typedef struct packed { logic [DW-1:0] d; logic [PW-1:0] p; } exp_t;
  exp_t exp_q[$];
  logic [DW-1:0] cur_div = '0;
  logic [PW-1:0] cur_port = '0;
  int  n_run = 0, n_fail = 0;
  bit  done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: sends nbits of word MSB first, pushes expected item if length fits mode.
  task automatic send(input logic [18:0] word, input int nbits);
    int need;
    exp_t e;
    need = mode ? 18 : 19;
    bus_en = 1'b1;
    wait_clk(2*T);
    for (int i = nbits-1; i >= 0; i--) begin
      bus_data = word[i];
      wait_clk(T);
      bus_clk = 1'b1;
      wait_clk(T);
      bus_clk = 1'b0;
      if (i == nbits/2) begin // R5: outputs hold mid-transfer
        check(div_o == cur_div, "R5 div mid-frame", int'(div_o), int'(cur_div));
        check(port_o == cur_port, "R5 port mid-frame", int'(port_o), int'(cur_port));
      end
    end
    wait_clk(T);
    if (nbits == need) begin
      if (mode) begin
        e.d = {1'b0, word[13:0]}; e.p = word[17:14];
      end else begin
        e.d = word[14:0]; e.p = word[18:15];
      end
      exp_q.push_back(e);
      cur_div = e.d; cur_port = e.p;
    end
    bus_en = 1'b0;
    wait_clk(4*T);
    check(exp_q.size() == 0, "R7 strobe seen for accepted word", exp_q.size(), 0);
    check(div_o == cur_div, "R6 div after word", int'(div_o), int'(cur_div));
    check(port_o == cur_port, "R6 port after word", int'(port_o), int'(cur_port));
  endtask

  // Monitor: pops one expected item per strobe.
  always @(negedge clk) begin
    if (rst_n && word_valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected strobe", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(div_o == e.d, "R2/R3 divisor", int'(div_o), int'(e.d));
        check(port_o == e.p, "R8 port bits", int'(port_o), int'(e.p));
      end
    end
  end

  initial begin
    wait_clk(5);
    check(div_o == '0, "R1 div reset", int'(div_o), 0);
    check(port_o == '0, "R1 port reset", int'(port_o), 0);
    check(word_valid_o == 1'b0, "R1 strobe reset", int'(word_valid_o), 0);
    rst_n = 1'b1;
    wait_clk(10);

    // R2: 14-bit divisor mode
    mode = 1'b1; wait_clk(8);
    send(19'h2_5A5C, 18);   // ports 1001, div 0x1A5C... from bits
    send(19'h3_FFFF, 18);   // all ones; div_o[14] must remain 0
    // R8: single port bit patterns
    send(19'h2_0001, 18);   // first bit only -> port_o[3]
    send(19'h0_4000, 18);   // fourth bit only -> port_o[0]

    // R6: wrong lengths in short mode
    send(19'h7_FFFF, 19);
    send(19'h0_1234, 17);
    send(19'h0_0000, 0);

    // R3: 15-bit divisor mode
    mode = 1'b0; wait_clk(8);
    send(19'h5_4321, 19);
    send(19'h0_4000, 19);   // divisor MSB only
    send(19'h1_2345, 18);   // R6: too short for long mode

    // R4: bus clock pulses while enable low must not be counted
    for (int k = 0; k < 5; k++) begin
      bus_data = 1'b1;
      wait_clk(T); bus_clk = 1'b1; wait_clk(T); bus_clk = 1'b0;
    end
    wait_clk(4*T);
    check(word_valid_o == 1'b0 && div_o == cur_div, "R4 idle clocks ignored",
          int'(div_o), int'(cur_div));
    send(19'h6_0F0F, 19);   // R4: must still be accepted

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule